// File: doc/BRIEF.md
# Bus Register and Event FIFO Readout Slave

This block is the bus-facing side of a multi-channel digitiser: a slave on a request/acknowledge bus with a 24-bit address and 16-bit data. A 6-bit module number, supplied at a pin from board switches, selects the 64 KB window the slave answers in. Inside that window sit a control word, one zero-suppression threshold per channel, and read access to one event FIFO per channel.

Samples come in from the conversion side, one per cycle, tagged with a channel. A sample is kept only if its 10-bit amplitude exceeds that channel's threshold. Software can read one channel's FIFO through a per-channel address, or drain every channel in turn through a single merged block-transfer address. Both kinds of read return 0xFFFF once there is nothing left to give.

The control word sets the stored-event count that raises the interrupt line. It also carries a clear bit that empties all FIFOs and drops the busy flag. The bus timing is a one-cycle request pulse, answered by a one-cycle acknowledge one clock later. Accesses the block does not serve are simply never acknowledged.

Top module: `evt_readout_slave`

## Requirements
- R1: The slave acts on a request only when address bits 21..16 equal `module_id`; otherwise it gives no acknowledge and changes no state.
- R2: A served request is acknowledged by `bus_ack` high for exactly one cycle, one clock after the request cycle, with `bus_rdata` valid in that same cycle; a served write returns 0x0000 on `bus_rdata`. After reset `bus_ack`, `busy` and `irq` are low and every FIFO is empty.
- R3: Requests with a modifier other than 0x3D, 0x3B or 0x3F, to an odd offset, to an offset outside 0x0000 and 0x0100..0x013E, or with a modifier not allowed at that offset, are not acknowledged and have no effect.
- R4: A write with modifier 0x3D to offset 0x0000 loads the 5-bit interrupt level from data bit 9 (level bit 4) and data bits 3..0 (level bits 3..0). A read there returns the level in the same bit positions, with the other bits zero.
- R5: A control write with data bit 8 set empties all FIFOs, clears `busy` and zeroes the stored-event count, in the same cycle as the level load.
- R6: A write with modifier 0x3D to offset 0x0100+2*j sets the 8-bit threshold of channel j to data bits 7..0. A sample for channel j is stored only if `smp_data[9:0]` is strictly greater than that threshold. Thresholds reset to 0.
- R7: A read with modifier 0x3D at offset 0x0100+2*j returns and removes the oldest word of channel j's FIFO.
- R8: Such a read of an empty FIFO returns 0xFFFF and changes nothing.
- R9: A read with modifier 0x3B or 0x3F at offset 0x0100 returns and removes the oldest word of the lowest-numbered non-empty channel, so channels drain in ascending order. Once all FIFOs are empty it returns 0xFFFF.
- R10: Each FIFO holds DEPTH words; a sample arriving at a full FIFO is dropped, and the stored words are kept.
- R11: `evt_end` sets `busy` and increments the stored-event count, which saturates at 31. `irq` is high while the level is non-zero and the count is at least the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| module_id | input | 6 | Module number from board switches |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after a served request |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 5 | Sample channel |
| smp_data | input | 16 | Sample word; bits 9..0 are the amplitude |
| evt_end | input | 1 | One-cycle end-of-event pulse |
| busy | output | 1 | Set by evt_end, cleared through the control word |
| irq | output | 1 | Stored-event count has reached the level |

## Verification
Every bus result appears in the cycle right after the request: acknowledge, read data and the FIFO pop all come from one register stage. The bench drives the request on a falling edge and samples `bus_ack` and `bus_rdata` on the next falling edge, so it reads exactly the acknowledge cycle. Samples and `evt_end` pulses are registered at the rising edge inside their one-cycle drive window. Any FIFO contents, `busy` or `irq` change they cause is therefore checked on or after the following falling edge. Rejected accesses are checked through the missing acknowledge and by reading the FIFO afterwards to show no word was removed.

// File: rtl/rfs_pkg.sv
// Shared constants and types for the bus readout slave.
// Assumes a byte-addressed 24-bit bus with 16-bit words.
package rfs_pkg;
    localparam logic [5:0]  AM_SINGLE  = 6'h3D;
    localparam logic [5:0]  AM_BLOCK_A = 6'h3B;
    localparam logic [5:0]  AM_BLOCK_B = 6'h3F;
    localparam logic [15:0] OFS_CTRL   = 16'h0000;
    localparam logic [15:0] OFS_WIN    = 16'h0100;
    localparam logic [15:0] END_WORD   = 16'hFFFF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL_W,
        ACC_CTRL_R,
        ACC_THR_W,
        ACC_ONE_R,
        ACC_ALL_R
    } acc_e;
endpackage

// File: rtl/rfs_fifo.sv
// Single-channel event FIFO.
// Assumes DEPTH is a power of two. A push at full is dropped; a pop at
// empty is ignored; clr empties the FIFO in one cycle.
module rfs_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // R10: a full FIFO that is not popped or cleared stays full on a push.
    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R8: popping an empty FIFO leaves it empty.
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/rfs_decode.sv
// Address and modifier decoder.
// Classifies one request into an access kind and a channel index.
// Anything not served decodes to ACC_NONE.
module rfs_decode
    import rfs_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                     req,
    input  logic                     we,
    input  logic [5:0]               am,
    input  logic [23:0]              addr,
    input  logic [5:0]               module_id,
    output acc_e                     kind,
    output logic [$clog2(NCH)-1:0]   chan
);
    localparam int CW = $clog2(NCH);
    localparam logic [16:0] WIN_END = 17'(OFS_WIN) + 17'(2 * NCH);

    logic [15:0] off, rel;
    logic        in_win;

    assign off    = addr[15:0];
    assign rel    = off - OFS_WIN;
    assign chan   = rel[CW:1];
    assign in_win = (off >= OFS_WIN) && ({1'b0, off} < WIN_END) && !off[0];

    // Access classification.
    always_comb begin
        kind = ACC_NONE;
        if (req && addr[21:16] == module_id) begin
            if (off == OFS_CTRL && am == AM_SINGLE) begin
                kind = we ? ACC_CTRL_W : ACC_CTRL_R;
            end else if (in_win && am == AM_SINGLE) begin
                kind = we ? ACC_THR_W : ACC_ONE_R;
            end else if (off == OFS_WIN && !we &&
                         (am == AM_BLOCK_A || am == AM_BLOCK_B)) begin
                kind = ACC_ALL_R;
            end
        end
    end
endmodule

// File: rtl/evt_readout_slave.sv
// Bus slave with control word, per-channel thresholds and per-channel
// event FIFOs, read singly or merged in ascending channel order.
// Assumes a one-cycle request pulse; the acknowledge follows one cycle later.
module evt_readout_slave
    import rfs_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    module_id,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [5:0]    bus_am,
    input  logic [23:0]   bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic          bus_ack,
    output logic [15:0]   bus_rdata,
    input  logic          smp_valid,
    input  logic [CW-1:0] smp_chan,
    input  logic [15:0]   smp_data,
    input  logic          evt_end,
    output logic          busy,
    output logic          irq
);
    acc_e           kind;
    logic [CW-1:0]  chan;
    logic [NCH-1:0] f_empty, f_full, f_push, f_pop;
    logic [15:0]    f_dout [NCH];
    logic [7:0]     thr [NCH];
    logic [4:0]     level, evcnt;
    logic           clr, keep, any;
    logic [CW-1:0]  sel;

    rfs_decode #(.NCH(NCH)) u_dec (
        .req(bus_req), .we(bus_we), .am(bus_am), .addr(bus_addr),
        .module_id(module_id), .kind(kind), .chan(chan)
    );

    assign clr  = (kind == ACC_CTRL_W) && bus_wdata[8];
    assign keep = smp_valid && (smp_data[9:0] > {2'b00, thr[smp_chan]});
    assign any  = ~&f_empty;
    assign irq  = (level != '0) && (evcnt >= level);

    // Lowest-numbered non-empty channel for the merged port.
    always_comb begin
        sel = '0;
        for (int j = NCH - 1; j >= 0; j--) begin
            if (!f_empty[j]) sel = CW'(j);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign f_push[g] = keep && (smp_chan == CW'(g));
        assign f_pop[g]  = ((kind == ACC_ONE_R) && (chan == CW'(g))) ||
                           ((kind == ACC_ALL_R) && any && (sel == CW'(g)));
        rfs_fifo #(.W(16), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .push(f_push[g]), .din(smp_data), .pop(f_pop[g]),
            .dout(f_dout[g]), .empty(f_empty[g]), .full(f_full[g])
        );
    end

    // Bus response: acknowledge and read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= (kind != ACC_NONE);
            case (kind)
                ACC_CTRL_R: bus_rdata <= {6'b0, level[4], 5'b0, level[3:0]};
                ACC_ONE_R:  bus_rdata <= f_empty[chan] ? END_WORD : f_dout[chan];
                ACC_ALL_R:  bus_rdata <= any ? f_dout[sel] : END_WORD;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // Threshold registers, written through the channel window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NCH; j++) thr[j] <= '0;
        end else if (kind == ACC_THR_W) begin
            thr[chan] <= bus_wdata[7:0];
        end
    end

    // Control word, busy flag and stored-event count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            evcnt <= '0;
            busy  <= 1'b0;
        end else begin
            if (kind == ACC_CTRL_W) level <= {bus_wdata[9], bus_wdata[3:0]};
            if (clr) begin
                evcnt <= '0;
                busy  <= 1'b0;
            end else if (evt_end) begin
                busy <= 1'b1;
                if (evcnt != 5'd31) evcnt <= evcnt + 1'b1;
            end
        end
    end

    // R1: a foreign module number is never acknowledged.
    p_foreign_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr[21:16] != module_id) |=> !bus_ack);

    // R2: an acknowledge always answers a request of the previous cycle.
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req));

    // R3: requests decoded as unserved are not acknowledged.
    p_unserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && kind == ACC_NONE) |=> !bus_ack);

    // R8: a single read of an empty FIFO returns the end word.
    p_empty_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_ONE_R && f_empty[chan]) |=> (bus_ack && bus_rdata == END_WORD));

    // R9: a merged read with every FIFO empty returns the end word.
    p_merged_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_ALL_R && !any) |=> (bus_ack && bus_rdata == END_WORD));

    // R5: the clear bit drops busy and the interrupt.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !irq));

    // R11: busy rises only after an end-of-event pulse.
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(evt_end));
endmodule

// File: tb/tb_evt_readout_slave.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps all channels with arithmetic expected values.
module tb_evt_readout_slave;
    localparam int NCH   = 32;
    localparam int DEPTH = 4;
    localparam int CW    = 5;
    localparam logic [5:0] MID = 6'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0]    bus_am = '0;
    logic [23:0]   bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_ack;
    logic [15:0]   bus_rdata;
    logic          smp_valid = 1'b0;
    logic [CW-1:0] smp_chan = '0;
    logic [15:0]   smp_data = '0;
    logic          evt_end = 1'b0;
    logic          busy, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    evt_readout_slave #(.NCH(NCH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .module_id(MID),
        .bus_req(bus_req), .bus_we(bus_we), .bus_am(bus_am),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .evt_end(evt_end), .busy(busy), .irq(irq)
    );

    function automatic logic [23:0] adr(input logic [5:0] id, input logic [15:0] off);
        return {2'b00, id, off};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access; ack and data are sampled in the acknowledge cycle.
    task automatic bus(input logic we, input logic [5:0] am, input logic [23:0] a,
                       input logic [15:0] wd, output logic ak, output logic [15:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_am = am; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        ak = bus_ack;
        rd = bus_rdata;
    endtask

    task automatic push(input int ch, input logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = CW'(ch); smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        evt_end = 1'b1;
        @(negedge clk);
        evt_end = 1'b0;
    endtask

    task automatic rd_one(input string tag, input int ch, input logic [15:0] exp);
        logic ak;
        logic [15:0] rd;
        bus(1'b0, 6'h3D, adr(MID, 16'h0100 + 16'(2 * ch)), 16'h0, ak, rd);
        check({tag, " ack"}, {31'b0, ak}, 32'd1);
        check({tag, " data"}, {16'b0, rd}, {16'b0, exp});
    endtask

    task automatic rd_all(input string tag, input logic [5:0] am, input logic [15:0] exp);
        logic ak;
        logic [15:0] rd;
        bus(1'b0, am, adr(MID, 16'h0100), 16'h0, ak, rd);
        check({tag, " ack"}, {31'b0, ak}, 32'd1);
        check({tag, " data"}, {16'b0, rd}, {16'b0, exp});
    endtask

    task automatic no_ack(input string tag, input logic we, input logic [5:0] am,
                          input logic [23:0] a);
        logic ak;
        logic [15:0] rd;
        bus(we, am, a, 16'h0, ak, rd);
        check(tag, {31'b0, ak}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ak;
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset ack", {31'b0, bus_ack}, 32'd0);
        check("R11 reset busy", {31'b0, busy}, 32'd0);
        check("R11 reset irq", {31'b0, irq}, 32'd0);
        for (int j = 0; j < NCH; j++) rd_one("R8 reset empty", j, 16'hFFFF);

        // R6: default threshold 0 drops amplitude 0, keeps amplitude 1
        push(7, 16'h0400);
        rd_one("R6 thr0 drop", 7, 16'hFFFF);
        push(7, 16'h0001);
        rd_one("R6 thr0 keep", 7, 16'h0001);

        // R6: per-channel thresholds j+10
        for (int j = 0; j < NCH; j++) begin
            bus(1'b1, 6'h3D, adr(MID, 16'h0100 + 16'(2 * j)), 16'hAB00 + 16'(j + 10), ak, rd);
            check("R2 thr write ack", {31'b0, ak}, 32'd1);
            check("R2 write data zero", {16'b0, rd}, 32'd0);
        end
        for (int j = 0; j < NCH; j++) begin
            push(j, 16'(j + 10));
            push(j, 16'(j + 11));
            push(j, 16'h0200 + 16'(j));
        end
        for (int j = 0; j < NCH; j++) begin
            rd_one("R6 R7 first", j, 16'(j + 11));
            rd_one("R7 second", j, 16'h0200 + 16'(j));
            rd_one("R8 drained", j, 16'hFFFF);
        end

        // R10: overfill channel 3
        for (int k = 0; k < 6; k++) push(3, 16'h0100 + 16'(k));
        for (int k = 0; k < DEPTH; k++) rd_one("R10 kept", 3, 16'h0100 + 16'(k));
        rd_one("R10 extra dropped", 3, 16'hFFFF);

        // R9: merged drain in ascending channel order
        push(31, 16'h0070);
        push(9, 16'h0060);
        push(2, 16'h0050);
        push(2, 16'h0051);
        rd_all("R9 m0", 6'h3B, 16'h0050);
        rd_all("R9 m1", 6'h3B, 16'h0051);
        rd_all("R9 m2", 6'h3B, 16'h0060);
        rd_all("R9 m3", 6'h3B, 16'h0070);
        rd_all("R9 end", 6'h3B, 16'hFFFF);
        push(1, 16'h0031);
        push(0, 16'h0030);
        rd_all("R9 alt m0", 6'h3F, 16'h0030);
        rd_all("R9 alt m1", 6'h3F, 16'h0031);
        rd_all("R9 alt end", 6'h3F, 16'hFFFF);

        // R1 and R3: rejected accesses leave channel 4 untouched
        push(4, 16'h0099);
        no_ack("R1 foreign id", 1'b0, 6'h3D, adr(6'd6, 16'h0108));
        no_ack("R3 bad modifier", 1'b0, 6'h39, adr(MID, 16'h0108));
        no_ack("R3 odd offset", 1'b0, 6'h3D, adr(MID, 16'h0109));
        no_ack("R3 past window", 1'b0, 6'h3D, adr(MID, 16'h0140));
        no_ack("R3 merged off base", 1'b0, 6'h3B, adr(MID, 16'h0108));
        no_ack("R3 merged write", 1'b1, 6'h3B, adr(MID, 16'h0100));
        no_ack("R3 ctrl block mod", 1'b0, 6'h3B, adr(MID, 16'h0000));
        no_ack("R3 bad mod thr write", 1'b1, 6'h39, adr(MID, 16'h0108));
        rd_one("R1 R3 no pop", 4, 16'h0099);
        push(4, 16'h000F);
        rd_one("R3 threshold unchanged", 4, 16'h000F);

        // R4: level fields
        bus(1'b1, 6'h3D, adr(MID, 16'h0000), 16'h0E7F, ak, rd);
        check("R4 ctrl write ack", {31'b0, ak}, 32'd1);
        bus(1'b0, 6'h3D, adr(MID, 16'h0000), 16'h0, ak, rd);
        check("R4 level 31 read", {16'b0, rd}, 32'h020F);
        bus(1'b1, 6'h3D, adr(MID, 16'h0000), 16'h0203, ak, rd);
        bus(1'b0, 6'h3D, adr(MID, 16'h0000), 16'h0, ak, rd);
        check("R4 level 19 read", {16'b0, rd}, 32'h0203);

        // R11: interrupt at the 19th event, count saturates
        for (int k = 1; k <= 40; k++) begin
            pulse_evt();
            check("R11 busy", {31'b0, busy}, 32'd1);
            check("R11 irq", {31'b0, irq}, (k >= 19) ? 32'd1 : 32'd0);
        end

        // R5: clear empties FIFOs, drops busy and the count
        push(5, 16'h0080);
        push(20, 16'h0081);
        bus(1'b1, 6'h3D, adr(MID, 16'h0000), 16'h0102, ak, rd);
        check("R5 clear ack", {31'b0, ak}, 32'd1);
        check("R5 busy cleared", {31'b0, busy}, 32'd0);
        check("R5 irq cleared", {31'b0, irq}, 32'd0);
        rd_one("R5 fifo emptied", 5, 16'hFFFF);
        rd_all("R5 merged empty", 6'h3F, 16'hFFFF);
        pulse_evt();
        check("R5 count restarted", {31'b0, irq}, 32'd0);
        pulse_evt();
        check("R5 R11 level 2 reached", {31'b0, irq}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule